// File: doc/BRIEF.md
# Debug halt and restart controller

This block sits between a debugger's access port and a core's debug-state logic. The debugger writes a command word. Its low bits ask the core to stop in debug state or to resume from it, or they wipe sticky status flags. The block turns an accepted stop or resume command into a level request toward the core. It keeps that request raised until the core pulses the matching acknowledge.

A packed status word reports several things the debugger polls. These are whether the core is stopped, whether a resume has completed, a sticky flag set by each retired instruction, and a field of sticky exception flags. A request is dropped when the core is already in the state it asks for. The clear commands act on the cycle of the write. When a flag's set event lands on the same cycle as its clear, the set wins.

Top module: `dbg_runctl`

## Requirements
- R1: A write with command bit 0 set, while the status halted bit (status bit 0) is 0, raises `halt_req` on the next cycle.
- R2: `halt_req` stays 1 until `core_entered` pulses. It is 0 on the cycle after that pulse, and status bit 0 is then 1.
- R3: A write with command bit 0 set while status bit 0 is 1 leaves `halt_req` at 0.
- R4: A write with command bit 1 set while status bit 0 is 1 raises `restart_req` on the next cycle. It holds until `core_exited` pulses, and then both `restart_req` and status bit 0 return to 0.
- R5: A write with command bit 1 set while status bit 0 is 0 leaves `restart_req` at 0.
- R6: The restarted flag (status bit 1) goes to 0 on the cycle after an accepted resume command. It goes to 1 on the cycle after `core_exited`.
- R7: Command bit 2 clears the sticky exception field (status bits 8:6) on the next cycle. Any bit whose `exc_event` input is 1 in the same cycle ends up 1, and each `exc_event` bit sets its own field bit.
- R8: Command bit 3 clears the pipeline-advanced flag (status bit 9). A `retire` pulse sets that flag, and it wins over a clear in the same cycle.
- R9: Command bit 4, bits 31:5, command bits written as 0, and data presented without `cmd_wr` change no output.
- R10: When bits 0 and 1 are both set in one write, only the command valid for the current state is taken. Bit 0 is taken when the core is running and bit 1 when it is halted; the other is dropped.
- R11: After synchronous reset the status word reads 0x002 (running, restarted) and neither request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | DATA_W | Command word |
| core_entered | input | 1 | Core acknowledge: entered debug state |
| core_exited | input | 1 | Core acknowledge: left debug state |
| retire | input | 1 | One pulse per retired instruction |
| exc_event | input | EXC_W | Exception events, one per sticky bit |
| halt_req | output | 1 | Pending stop request to the core |
| restart_req | output | 1 | Pending resume request to the core |
| status | output | EXC_W+7 | Halted, restarted, sticky exceptions, pipeline-advanced |

## Verification
Every output is a flop, so every result is due one clock edge after its stimulus. This holds for a command write, an acknowledge pulse, a retire pulse and an exception event alike. The bench drives each stimulus on a falling edge and lets one rising edge pass. It then compares `halt_req`, `restart_req` and the whole status word on the next falling edge. A request that is held is checked again on idle cycles that follow, to show it stays raised.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;
  // command word bit positions
  localparam int CMD_HALT    = 0;
  localparam int CMD_RESTART = 1;
  localparam int CMD_CLR_EXC = 2;
  localparam int CMD_CLR_PA  = 3;
  localparam int CMD_USED    = 4;

  // status word layout
  localparam int ST_HALTED    = 0;
  localparam int ST_RESTARTED = 1;
  localparam int ST_EXC_LSB   = 6;

  typedef struct packed {
    logic halt;
    logic restart;
    logic clr_exc;
    logic clr_pa;
  } cmd_t;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_runctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              in_debug,
  output cmd_t              acc
);
  logic unused_hi;
  assign unused_hi = ^cmd_data[DATA_W-1:CMD_USED];

  always_comb begin
    acc         = '0;
    acc.halt    = cmd_wr & cmd_data[CMD_HALT] & ~in_debug;
    acc.restart = cmd_wr & cmd_data[CMD_RESTART] & in_debug;
    acc.clr_exc = cmd_wr & cmd_data[CMD_CLR_EXC];
    acc.clr_pa  = cmd_wr & cmd_data[CMD_CLR_PA];
  end
endmodule

// File: rtl/dbg_req_tracker.sv
module dbg_req_tracker (
  input  logic clk,
  input  logic rst,
  input  logic acc_halt,
  input  logic acc_restart,
  input  logic core_entered,
  input  logic core_exited,
  output logic in_debug,
  output logic halt_req,
  output logic restart_req,
  output logic restarted
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_debug    <= 1'b0;
      halt_req    <= 1'b0;
      restart_req <= 1'b0;
      restarted   <= 1'b1;
    end else begin
      if (core_entered)
        in_debug <= 1'b1;
      else if (core_exited)
        in_debug <= 1'b0;
      halt_req    <= (halt_req | acc_halt) & ~core_entered;
      restart_req <= (restart_req | acc_restart) & ~core_exited;
      if (core_exited)
        restarted <= 1'b1;
      else if (acc_restart)
        restarted <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_sticky_bank.sv
module dbg_sticky_bank #(
  parameter int EXC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_exc,
  input  logic             clr_pa,
  input  logic             retire,
  input  logic [EXC_W-1:0] exc_event,
  output logic [EXC_W-1:0] sticky_exc,
  output logic             pipe_adv
);
  for (genvar i = 0; i < EXC_W; i++) begin : g_exc
    always_ff @(posedge clk) begin
      if (rst)
        sticky_exc[i] <= 1'b0;
      else
        sticky_exc[i] <= exc_event[i] | (sticky_exc[i] & ~clr_exc);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pipe_adv <= 1'b0;
    else
      pipe_adv <= retire | (pipe_adv & ~clr_pa);
  end
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
  import dbg_runctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXC_W  = 3,
  localparam int PA_BIT = ST_EXC_LSB + EXC_W,
  localparam int STAT_W = PA_BIT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              core_entered,
  input  logic              core_exited,
  input  logic              retire,
  input  logic [EXC_W-1:0]  exc_event,
  output logic              halt_req,
  output logic              restart_req,
  output logic [STAT_W-1:0] status
);
  cmd_t             acc;
  logic             in_debug;
  logic             restarted;
  logic [EXC_W-1:0] sticky_exc;
  logic             pipe_adv;

  dbg_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd_wr   (cmd_wr),
    .cmd_data (cmd_data),
    .in_debug (in_debug),
    .acc      (acc)
  );

  dbg_req_tracker u_req (
    .clk          (clk),
    .rst          (rst),
    .acc_halt     (acc.halt),
    .acc_restart  (acc.restart),
    .core_entered (core_entered),
    .core_exited  (core_exited),
    .in_debug     (in_debug),
    .halt_req     (halt_req),
    .restart_req  (restart_req),
    .restarted    (restarted)
  );

  dbg_sticky_bank #(.EXC_W(EXC_W)) u_sticky (
    .clk        (clk),
    .rst        (rst),
    .clr_exc    (acc.clr_exc),
    .clr_pa     (acc.clr_pa),
    .retire     (retire),
    .exc_event  (exc_event),
    .sticky_exc (sticky_exc),
    .pipe_adv   (pipe_adv)
  );

  always_comb begin
    status                               = '0;
    status[ST_HALTED]                    = in_debug;
    status[ST_RESTARTED]                 = restarted;
    status[ST_EXC_LSB +: EXC_W]          = sticky_exc;
    status[PA_BIT]                       = pipe_adv;
  end
endmodule

// File: rtl/dbg_runctl_chk.sv
module dbg_runctl_chk
  import dbg_runctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXC_W  = 3,
  localparam int PA_BIT = ST_EXC_LSB + EXC_W,
  localparam int STAT_W = PA_BIT + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_wr,
  input logic [DATA_W-1:0] cmd_data,
  input logic              core_entered,
  input logic              core_exited,
  input logic              retire,
  input logic [EXC_W-1:0]  exc_event,
  input logic              halt_req,
  input logic              restart_req,
  input logic [STAT_W-1:0] status
);
  logic unused_chk;
  assign unused_chk = ^cmd_data[DATA_W-1:CMD_USED] ^ cmd_data[CMD_CLR_EXC];

  p_halt_held_r2: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !core_entered) |=> halt_req);

  p_halt_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (status[ST_HALTED] && cmd_wr && cmd_data[CMD_HALT]) |=> !halt_req);

  p_restart_held_r4: assert property (@(posedge clk) disable iff (rst)
    (restart_req && !core_exited) |=> restart_req);

  p_restart_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (!status[ST_HALTED] && !restart_req && cmd_wr && cmd_data[CMD_RESTART]) |=> !restart_req);

  p_restarted_set_r6: assert property (@(posedge clk) disable iff (rst)
    core_exited |=> (status[ST_RESTARTED] && !status[ST_HALTED]));

  p_exc_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (exc_event != '0) |=>
      ((status[ST_EXC_LSB +: EXC_W] & $past(exc_event)) == $past(exc_event)));

  p_pa_set_r8: assert property (@(posedge clk) disable iff (rst)
    retire |=> status[PA_BIT]);

  p_pa_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_data[CMD_CLR_PA] && !retire) |=> !status[PA_BIT]);
endmodule

bind dbg_runctl dbg_runctl_chk #(.DATA_W(DATA_W), .EXC_W(EXC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_wr       (cmd_wr),
  .cmd_data     (cmd_data),
  .core_entered (core_entered),
  .core_exited  (core_exited),
  .retire       (retire),
  .exc_event    (exc_event),
  .halt_req     (halt_req),
  .restart_req  (restart_req),
  .status       (status)
);

// File: tb/dbg_runctl_test.sv
`timescale 1ns/1ps
module dbg_runctl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_wr;
  logic [31:0] cmd_data;
  logic        core_entered;
  logic        core_exited;
  logic        retire;
  logic [2:0]  exc_event;
  logic        halt_req;
  logic        restart_req;
  logic [9:0]  status;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dbg_runctl uut (
    .clk          (clk),
    .rst          (rst),
    .cmd_wr       (cmd_wr),
    .cmd_data     (cmd_data),
    .core_entered (core_entered),
    .core_exited  (core_exited),
    .retire       (retire),
    .exc_event    (exc_event),
    .halt_req     (halt_req),
    .restart_req  (restart_req),
    .status       (status)
  );

  // row: wr, cmd[4:0], entered, exited, retire, exc[2:0] | exp halt_req, exp restart_req, exp status[9:0]
  localparam int NV = 18;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 5'b00010, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 10'h002}, // R5 restart while running
    {1'b1, 5'b00001, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 10'h002}, // R1 halt accepted
    {1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 10'h002}, // R2 held
    {1'b0, 5'b00000, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 10'h003}, // R2 entry ack
    {1'b1, 5'b00001, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 10'h003}, // R3 halt while halted
    {1'b1, 5'b00011, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 10'h001}, // R10 both while halted
    {1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 10'h001}, // R4 held
    {1'b0, 5'b00000, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 10'h002}, // R6 exit ack
    {1'b1, 5'b00011, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 10'h002}, // R10 both while running
    {1'b0, 5'b00000, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 10'h003}, // R2 entry ack
    {1'b0, 5'b00000, 1'b0, 1'b0, 1'b1, 3'b101, 1'b0, 1'b0, 10'h343}, // R8 retire, R7 events
    {1'b1, 5'b00100, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 10'h203}, // R7 clear exc
    {1'b1, 5'b01000, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 10'h003}, // R8 clear pa
    {1'b1, 5'b00100, 1'b0, 1'b0, 1'b0, 3'b010, 1'b0, 1'b0, 10'h083}, // R7 set beats clear
    {1'b1, 5'b01000, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 1'b0, 10'h283}, // R8 set beats clear
    {1'b1, 5'b10000, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 10'h283}, // R9 bit 4
    {1'b1, 5'b00000, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 10'h283}, // R9 zeros
    {1'b1, 5'b01100, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 10'h003}  // R7 R8 both clears
  };
  localparam int VTAG [NV] = '{5,1,2,2,3,10,4,6,10,2,8,7,8,7,8,9,9,7};

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    cmd_wr = 1'b0; cmd_data = '0; core_entered = 1'b0;
    core_exited = 1'b0; retire = 1'b0; exc_event = '0;
  endtask

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %03h expected %03h", req, got, exp);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    @(negedge clk);
    tick();
    tick();
    rst = 1'b0;
    check("R11 reset", {halt_req, restart_req, status}, {2'b00, 10'h002});

    for (int i = 0; i < NV; i++) begin
      cmd_wr       = VEC[i][23];
      cmd_data     = {27'd0, VEC[i][22:18]};
      core_entered = VEC[i][17];
      core_exited  = VEC[i][16];
      retire       = VEC[i][15];
      exc_event    = VEC[i][14:12];
      tick();
      idle_inputs();
      check($sformatf("R%0d row %0d", VTAG[i], i), {halt_req, restart_req, status}, VEC[i][11:0]);
    end

    // R9: command bits without a strobe are ignored (core halted, restart would be valid)
    cmd_wr = 1'b0; cmd_data = 32'h0000_000F;
    tick();
    idle_inputs();
    check("R9 no strobe", {halt_req, restart_req, status}, {2'b00, 10'h003});

    // R9: upper bits 31:4 written as ones have no effect
    cmd_wr = 1'b1; cmd_data = 32'hFFFF_FFF0;
    tick();
    idle_inputs();
    check("R9 upper bits", {halt_req, restart_req, status}, {2'b00, 10'h003});

    // R4 / R6: resume pending, then reset mid-request
    cmd_wr = 1'b1; cmd_data = 32'h0000_0002;
    tick();
    idle_inputs();
    check("R4 resume raised", {halt_req, restart_req, status}, {2'b01, 10'h001});
    retire = 1'b1; exc_event = 3'b111;
    tick();
    idle_inputs();
    check("R6 restarted low while pending", {halt_req, restart_req, status}, {2'b01, 10'h3C1});
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R11 reset mid-request", {halt_req, restart_req, status}, {2'b00, 10'h002});

    // R1 / R2: acknowledge arriving with the write itself leaves no request
    cmd_wr = 1'b1; cmd_data = 32'h0000_0001; core_entered = 1'b1;
    tick();
    idle_inputs();
    check("R2 ack with write", {halt_req, restart_req, status}, {2'b00, 10'h003});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule